// File: doc/BRIEF.md
# Pipelined Byte-Lane SRAM Core

This block is the storage and data-path part of a synchronous pipelined static memory. Each word holds 18 bits, arranged as two 9-bit lanes; each lane is 8 data bits plus 1 parity bit. On every rising clock edge the block takes one address and one decoded command from an external burst sequencer. The command is no-operation, access or deselect. For an access, three active-low write enables decide whether the cycle writes or reads. A global enable writes the whole word. A master enable combines with one enable per lane to write single lanes. When no write enable is active, the access is a read.

Reads pass through an address register and then an output register. Data for an address that is captured on one edge appears on the bus after the following edge. The bidirectional data bus is split into an input port, an output port and a drive-enable port. A two-stage drive pipeline sets the drive enable. Any sampled lane write clears it at once. After a deselect it stays on for one more cycle. The active-low output enable gates it without waiting for a clock. Memory depth is a parameter, and words hold no defined value until they are written.

Top module: `pbsram_core`

## Requirements
- R1: A word is two 9-bit lanes. Lane 0 is bits 8:0 and is controlled by `lane_we_n_i[0]`. Lane 1 is bits 17:9 and is controlled by `lane_we_n_i[1]`.
- R2: An access read (cmd_i = 2'b01, no write enable active) sampled on edge N puts the addressed word on `dq_o` after edge N+1. `dq_oe_o` also rises after edge N+1, provided `oe_n_i` is low and no write or deselect comes between.
- R3: An access with `gwe_n_i` low writes all 18 bits, whatever `bwe_n_i` and `lane_we_n_i` are.
- R4: An access with `gwe_n_i` high writes lane i only when `bwe_n_i` is low and `lane_we_n_i[i]` is low. The other lane keeps its stored value.
- R5: An access with `gwe_n_i` high, and with either `bwe_n_i` high or both lane enables high, is a read.
- R6: On any edge where a write is sampled, `dq_oe_o` is low after that edge, whatever `oe_n_i` is and whatever the command is.
- R7: For a deselect (cmd_i = 2'b10) sampled on edge M, the drive state after M matches the state before M, and `dq_o` keeps its data. `dq_oe_o` is low after edge M+1 unless a read has started since.
- R8: `oe_n_i` high forces `dq_oe_o` low at once, with no clock edge needed. Returning it low restores the pipelined drive state.
- R9: While `rst` is high at an edge, the read and drive pipelines are cleared, so `dq_oe_o` is low afterwards.
- R10: A no-operation (cmd_i = 2'b00, and also 2'b11) writes nothing, starts no read, and keeps `dq_o` and the drive state unchanged, unless write enables are sampled (R6).
- R11: Write data is captured on the same edge as the write command and address. A later read of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 2 | Command: 00 no-op, 01 access, 10 deselect, 11 no-op |
| addr_i | input | ADDR_W | Word address |
| gwe_n_i | input | 1 | Global write enable, active low |
| bwe_n_i | input | 1 | Lane-write master enable, active low |
| lane_we_n_i | input | 2 | Per-lane write enables, active low |
| dq_i | input | 18 | Write data |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| dq_o | output | 18 | Registered read data |
| dq_oe_o | output | 1 | Data bus drive enable |

## Verification
If the read token were lost or delayed, the drive enable would show it one edge late or not at all, and a read would show stale or wrong data on the second edge after the address is captured. If the lane strobe decode were wrong, the fault would stay in storage until the next read of that word. The bench therefore reads every partially written word back, checking both lanes. A drive pipeline that ignored write kills or collapsed to a single deselect stage would show a wrong `dq_oe_o` on the edge just after the write or deselect.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
    localparam int LANES  = 2;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        CMD_NOP    = 2'b00,
        CMD_ACCESS = 2'b01,
        CMD_DESEL  = 2'b10,
        CMD_NOP2   = 2'b11
    } cmd_e;

    typedef logic [LANES-1:0][LANE_W-1:0] word_t;

    typedef struct packed {
        logic             gwe_n;
        logic             bwe_n;
        logic [LANES-1:0] lane_n;
    } wen_t;

    // Lanes that a set of write enables asks to write (active high).
    function automatic logic [LANES-1:0] lane_strobe(wen_t w);
        if (!w.gwe_n)
            return '1;
        else if (!w.bwe_n)
            return ~w.lane_n;
        else
            return '0;
    endfunction
endpackage

// File: rtl/pbs_wen_dec.sv
module pbs_wen_dec
    import pbs_pkg::*;
(
    input  cmd_e             cmd_i,
    input  wen_t             wen_i,
    output logic [LANES-1:0] lane_we_o,
    output logic             wr_seen_o,
    output logic             rd_start_o,
    output logic             desel_o
);
    logic [LANES-1:0] strobe;

    always_comb begin
        strobe     = lane_strobe(wen_i);
        wr_seen_o  = |strobe;
        lane_we_o  = (cmd_i == CMD_ACCESS) ? strobe : '0;
        rd_start_o = (cmd_i == CMD_ACCESS) && !wr_seen_o;
        desel_o    = (cmd_i == CMD_DESEL);
    end
endmodule

// File: rtl/pbs_array.sv
module pbs_array
    import pbs_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  lane_we_i,
    input  logic              rd_start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  word_t             wdata_i,
    output word_t             dout_o
);
    logic              rd_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 1'b0;
        else     rd_q <= rd_start_i;
    end

    always_ff @(posedge clk) begin
        addr_q <= addr_i;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        logic [LANE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (lane_we_i[g]) bank[addr_i] <= wdata_i[g];
        end

        always_ff @(posedge clk) begin
            if (rst)       q <= '0;
            else if (rd_q) q <= bank[addr_q];
        end

        assign dout_o[g] = q;
    end

    // R10: the output register changes only when a read is in its second stage
    p_dout_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_q |=> $stable(dout_o));
endmodule

// File: rtl/pbs_drive.sv
module pbs_drive (
    input  logic clk,
    input  logic rst,
    input  logic rd_start_i,
    input  logic wr_seen_i,
    input  logic desel_i,
    output logic drv_o
);
    logic tok_q;
    logic drv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tok_q <= 1'b0;
            drv_q <= 1'b0;
        end else begin
            if (rd_start_i)                tok_q <= 1'b1;
            else if (desel_i || wr_seen_i) tok_q <= 1'b0;
            drv_q <= wr_seen_i ? 1'b0 : tok_q;
        end
    end

    assign drv_o = drv_q;

    p_write_kills_drive_r6: assert property (@(posedge clk) disable iff (rst)
        wr_seen_i |=> !drv_q);

    p_desel_second_edge_r7: assert property (@(posedge clk) disable iff (rst)
        desel_i |=> ##1 !drv_q);

    p_token_reaches_drive_r2: assert property (@(posedge clk) disable iff (rst)
        (tok_q && !wr_seen_i) |=> drv_q);

    p_quiet_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!drv_q && !tok_q));
endmodule

// File: rtl/pbsram_core.sv
module pbsram_core
    import pbs_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              gwe_n_i,
    input  logic              bwe_n_i,
    input  logic [1:0]        lane_we_n_i,
    input  logic [17:0]       dq_i,
    input  logic              oe_n_i,
    output logic [17:0]       dq_o,
    output logic              dq_oe_o
);
    cmd_e             cmd;
    wen_t             wen;
    logic [LANES-1:0] lane_we;
    logic             wr_seen;
    logic             rd_start;
    logic             desel;
    logic             drv;
    word_t            dout;

    assign cmd = cmd_e'(cmd_i);
    assign wen = '{gwe_n: gwe_n_i, bwe_n: bwe_n_i, lane_n: lane_we_n_i};

    pbs_wen_dec u_dec (
        .cmd_i      (cmd),
        .wen_i      (wen),
        .lane_we_o  (lane_we),
        .wr_seen_o  (wr_seen),
        .rd_start_o (rd_start),
        .desel_o    (desel)
    );

    pbs_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_arr (
        .clk        (clk),
        .rst        (rst),
        .lane_we_i  (lane_we),
        .rd_start_i (rd_start),
        .addr_i     (addr_i),
        .wdata_i    (word_t'(dq_i)),
        .dout_o     (dout)
    );

    pbs_drive u_drv (
        .clk        (clk),
        .rst        (rst),
        .rd_start_i (rd_start),
        .wr_seen_i  (wr_seen),
        .desel_i    (desel),
        .drv_o      (drv)
    );

    assign dq_o    = dout;
    assign dq_oe_o = drv & ~oe_n_i;
endmodule

// File: tb/sim_pbsram_core.sv
module sim_pbsram_core;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;

    typedef struct packed {
        logic [1:0]    cmd;
        logic [AW-1:0] addr;
        logic          gwe_n;
        logic          bwe_n;
        logic [1:0]    lane_n;
        logic [17:0]   wdata;
        logic          oe_n;
        logic          exp_oe;
        logic          chk_dq;
        logic [17:0]   exp_dq;
    } vec_t;

    localparam int NV = 24;
    // Expectations hold after the edge that samples the vector's inputs.
    localparam vec_t TBL [NV] = '{
        '{2'b01, 10'd5, 1'b0, 1'b1, 2'b11, 18'h15A5A, 1'b0, 1'b0, 1'b0, 18'h0},     // 0  R3 full write
        '{2'b01, 10'd9, 1'b0, 1'b0, 2'b11, 18'h3FFFF, 1'b0, 1'b0, 1'b0, 18'h0},     // 1  R3 lanes ignored
        '{2'b01, 10'd9, 1'b1, 1'b0, 2'b10, {9'h155, 9'h0AB}, 1'b0, 1'b0, 1'b0, 18'h0}, // 2  R4 R1 lane 0
        '{2'b01, 10'd9, 1'b1, 1'b0, 2'b01, {9'h022, 9'h133}, 1'b0, 1'b0, 1'b0, 18'h0}, // 3  R4 R1 lane 1
        '{2'b01, 10'd5, 1'b1, 1'b1, 2'b00, 18'h0, 1'b0, 1'b0, 1'b0, 18'h0},         // 4  R5 read (master off)
        '{2'b01, 10'd9, 1'b1, 1'b0, 2'b11, 18'h0, 1'b0, 1'b1, 1'b1, 18'h15A5A},     // 5  R5 read, R2 data
        '{2'b00, 10'd0, 1'b1, 1'b1, 2'b11, 18'h0, 1'b0, 1'b1, 1'b1, 18'h044AB},     // 6  R2 R4 R1 merged lanes
        '{2'b00, 10'd0, 1'b1, 1'b1, 2'b11, 18'h0, 1'b0, 1'b1, 1'b1, 18'h044AB},     // 7  R10 hold
        '{2'b10, 10'd0, 1'b1, 1'b1, 2'b11, 18'h0, 1'b0, 1'b1, 1'b1, 18'h044AB},     // 8  R7 still driving
        '{2'b00, 10'd0, 1'b1, 1'b1, 2'b11, 18'h0, 1'b0, 1'b0, 1'b1, 18'h044AB},     // 9  R7 off
        '{2'b01, 10'd5, 1'b1, 1'b1, 2'b11, 18'h0, 1'b0, 1'b0, 1'b0, 18'h0},         // 10 R2 first edge
        '{2'b00, 10'd0, 1'b1, 1'b1, 2'b11, 18'h0, 1'b1, 1'b0, 1'b1, 18'h15A5A},     // 11 R8 gated
        '{2'b00, 10'd0, 1'b1, 1'b1, 2'b11, 18'h0, 1'b0, 1'b1, 1'b1, 18'h15A5A},     // 12 R8 restored
        '{2'b01, 10'd5, 1'b0, 1'b1, 2'b00, 18'h00F0F, 1'b0, 1'b0, 1'b0, 18'h0},     // 13 R6 R11 write
        '{2'b01, 10'd5, 1'b1, 1'b1, 2'b11, 18'h0, 1'b0, 1'b0, 1'b0, 18'h0},         // 14 read back
        '{2'b00, 10'd0, 1'b1, 1'b1, 2'b11, 18'h0, 1'b0, 1'b1, 1'b1, 18'h00F0F},     // 15 R11
        '{2'b00, 10'd5, 1'b0, 1'b1, 2'b11, 18'h11111, 1'b0, 1'b0, 1'b1, 18'h00F0F}, // 16 R6 R10 no-op write
        '{2'b01, 10'd5, 1'b1, 1'b1, 2'b11, 18'h0, 1'b0, 1'b0, 1'b0, 18'h0},         // 17 read
        '{2'b00, 10'd0, 1'b1, 1'b1, 2'b11, 18'h0, 1'b0, 1'b1, 1'b1, 18'h00F0F},     // 18 R10 unchanged
        '{2'b10, 10'd0, 1'b0, 1'b1, 2'b11, 18'h0, 1'b0, 1'b0, 1'b1, 18'h00F0F},     // 19 R6 beats R7
        '{2'b01, 10'd9, 1'b1, 1'b1, 2'b11, 18'h0, 1'b0, 1'b0, 1'b0, 18'h0},         // 20 read
        '{2'b11, 10'd0, 1'b1, 1'b1, 2'b11, 18'h0, 1'b0, 1'b1, 1'b1, 18'h044AB},     // 21 R10 code 11
        '{2'b10, 10'd0, 1'b1, 1'b1, 2'b11, 18'h0, 1'b0, 1'b1, 1'b1, 18'h044AB},     // 22 R7
        '{2'b00, 10'd0, 1'b1, 1'b1, 2'b11, 18'h0, 1'b0, 1'b0, 1'b1, 18'h044AB}      // 23 R7
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    cmd;
    logic [AW-1:0] addr;
    logic          gwe_n, bwe_n;
    logic [1:0]    lane_n;
    logic [17:0]   wdata;
    logic          oe_n;
    logic [17:0]   dq_o;
    logic          dq_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbsram_core #(.DEPTH(1024)) u0 (
        .clk(clk), .rst(rst), .cmd_i(cmd), .addr_i(addr),
        .gwe_n_i(gwe_n), .bwe_n_i(bwe_n), .lane_we_n_i(lane_n),
        .dq_i(wdata), .oe_n_i(oe_n), .dq_o(dq_o), .dq_oe_o(dq_oe)
    );

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cmd = 2'b00; addr = '0; gwe_n = 1'b1; bwe_n = 1'b1;
        lane_n = 2'b11; wdata = '0; oe_n = 1'b0;
    endtask

    task automatic step(input logic [1:0] c, input logic [AW-1:0] a);
        @(negedge clk);
        cmd = c; addr = a; gwe_n = 1'b1; bwe_n = 1'b1; lane_n = 2'b11;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        chk("R9 reset drive", {17'b0, dq_oe}, 18'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cmd = TBL[i].cmd; addr = TBL[i].addr; gwe_n = TBL[i].gwe_n;
            bwe_n = TBL[i].bwe_n; lane_n = TBL[i].lane_n;
            wdata = TBL[i].wdata; oe_n = TBL[i].oe_n;
            @(posedge clk);
            #2;
            chk($sformatf("vec %0d drive", i), {17'b0, dq_oe}, {17'b0, TBL[i].exp_oe});
            if (TBL[i].chk_dq)
                chk($sformatf("vec %0d data", i), dq_o, TBL[i].exp_dq);
        end

        // R8: output enable acts without a clock edge
        step(2'b01, 10'd9);
        step(2'b00, 10'd0);
        chk("R2 drive on", {17'b0, dq_oe}, 18'h1);
        @(negedge clk);
        #1 oe_n = 1'b1;
        #1 chk("R8 async off", {17'b0, dq_oe}, 18'h0);
        oe_n = 1'b0;
        #1 chk("R8 async on", {17'b0, dq_oe}, 18'h1);

        // R9: reset in the middle of driving
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        chk("R9 reset clears drive", {17'b0, dq_oe}, 18'h0);
        @(negedge clk);
        rst = 1'b0;
        step(2'b00, 10'd0);
        chk("R9 stays off", {17'b0, dq_oe}, 18'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule